// File: doc/BRIEF.md
# MSI-X Vector Table Interrupt Controller

This block turns internal interrupt events into message writes. It keeps a table with one entry for each interrupt vector. Each entry holds a 64-bit message address, a 32-bit message data word and a vector-control word. Bit 0 of the vector-control word masks that vector on its own. The block also keeps an array of pending bits, one per vector. A control register holds the global enable and a function mask that blocks every vector at once. The same register reports the capability identifier and the number of table entries.

Software reaches the control register, the table and the pending array through a simple word-addressed register port. Reads return data one cycle later. Each internal event is first recorded as a pending bit. It is sent as a message when its vector is unmasked, the block is enabled and the plain message-interrupt mechanism is not active. Messages leave through a valid/ready output, and only one message is outstanding at a time.

Word map, as word addresses:
- Word 0: control register.
- Word 1: byte offset of the table.
- Word 2: byte offset of the pending array.
- Table entry i, field f: word TBL_BASE + 4·i + f. Field 0 is address low, 1 is address high, 2 is data and 3 is vector control.
- Pending word k: word PBA_BASE + k. Bit j of that word is vector 32·k + j.

Top module: `msix_vec_ctrl`

## Requirements
- R1: Control word 0 reads {enable[31], function mask[30], 3'b0, NVEC-1 in [26:16], 8'h00, 8'h11 in [7:0]}. A write updates only bits 31 and 30. Word 1 reads TBL_BASE·4 and word 2 reads PBA_BASE·4.
- R2: The address-low, address-high and data fields of each table entry read back exactly as written. Vector control keeps only bit 0, so all other bits read 0.
- R3: After reset, every vector-control mask bit reads 1, enable and function mask read 0, every pending bit reads 0 and msg_valid is 0.
- R4: A request on irq_req[i] for an unmasked vector, with enable 1, raises msg_valid two clock edges after the request is sampled. msg_addr is {entry i address high, address low} and msg_data is entry i's data.
- R5: A request on a vector whose own mask bit is 1 sets its pending bit, and no message goes out. When that mask bit is cleared, the message is sent on the following edge.
- R6: While the function mask is 1, no vector is sent, whatever its own mask bit. When the function mask is cleared, every pending unmasked vector is sent.
- R7: Pending vectors are sent lowest index first. While msg_valid is 1 and msg_ready is 0, msg_valid, msg_addr and msg_data hold.
- R8: While msi_active is 1, no message is started and pending bits are kept.
- R9: While enable is 0, no message is started and requests are still recorded as pending.
- R10: Writes to the pending array have no effect.
- R11: A vector's pending bit is cleared when its message is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | AW | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| irq_req | input | NVEC | One-cycle event pulses, one bit per vector |
| msi_active | input | 1 | The plain message-interrupt mechanism is active |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
First, every vector is raised alone while unmasked. This checks, for each entry, that the two-edge latency and the right address and data hold, and that the message stays stable under back-pressure. Next, all vectors are raised at once under per-vector masks and then under the function mask. The two release orders show that the layered masks are separate and that service is lowest index first. Single requests made while msi_active is high or enable is low separate blocking from dropping. A masked vector released by its own mask bit, and a write to the pending array, show that pending state survives and is read-only.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam logic [7:0] CAP_ID    = 8'h11;
  localparam int         EN_BIT    = 31;
  localparam int         FMASK_BIT = 30;

  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_VCTRL   = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_TBL  = 2'd2,
    SRC_PBA  = 2'd3
  } rsrc_e;
endpackage

// File: rtl/msix_table.sv
module msix_table
  import msix_pkg::*;
#(
  parameter int NVEC = 16,
  parameter int IW   = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  fld_e            wr_fld,
  input  logic [31:0]     wr_data,
  input  logic [IW-1:0]   rd_idx,
  input  fld_e            rd_fld,
  output logic [31:0]     rd_data,
  input  logic            ld_en,
  input  logic [IW-1:0]   ld_idx,
  output logic [63:0]     ld_addr,
  output logic [31:0]     ld_data,
  output logic [NVEC-1:0] vmask
);
  // Address and data words sit in plain arrays with a single write port
  // and registered reads, so each array can map onto block RAM.
  logic [31:0] lo_mem  [NVEC];
  logic [31:0] hi_mem  [NVEC];
  logic [31:0] dat_mem [NVEC];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_fld)
        FLD_ADDR_LO: lo_mem[wr_idx]  <= wr_data;
        FLD_ADDR_HI: hi_mem[wr_idx]  <= wr_data;
        FLD_DATA:    dat_mem[wr_idx] <= wr_data;
        default:     ;
      endcase
    end
  end

  // Register-port read.
  always_ff @(posedge clk) begin
    case (rd_fld)
      FLD_ADDR_LO: rd_data <= lo_mem[rd_idx];
      FLD_ADDR_HI: rd_data <= hi_mem[rd_idx];
      FLD_DATA:    rd_data <= dat_mem[rd_idx];
      default:     rd_data <= {31'b0, vmask[rd_idx]};
    endcase
  end

  // Message read. It is loaded only at launch, so it holds while offered.
  always_ff @(posedge clk) begin
    if (ld_en) begin
      ld_addr <= {hi_mem[ld_idx], lo_mem[ld_idx]};
      ld_data <= dat_mem[ld_idx];
    end
  end

  // The mask bits are flops, because every vector is checked in parallel.
  always_ff @(posedge clk) begin
    if (rst)
      vmask <= '1;
    else if (wr_en && wr_fld == FLD_VCTRL)
      vmask[wr_idx] <= wr_data[0];
  end
endmodule

// File: rtl/msix_pba.sv
module msix_pba #(
  parameter int NVEC = 16,
  parameter int IW   = $clog2(NVEC),
  parameter int PW   = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NVEC-1:0] set_vec,
  input  logic            clr_en,
  input  logic [IW-1:0]   clr_idx,
  input  logic [NVEC-1:0] elig,
  input  logic [PW-1:0]   rd_word,
  output logic [31:0]     rd_data,
  output logic [NVEC-1:0] pend,
  output logic            pick_valid,
  output logic [IW-1:0]   pick_idx
);
  localparam int PADW = (1 << PW) * 32;

  logic [NVEC-1:0] clr_vec;
  logic [PADW-1:0] pad;

  always_comb begin
    clr_vec = '0;
    if (clr_en) clr_vec[clr_idx] = 1'b1;
  end

  // A new event wins over a clear in the same cycle, so it is not lost.
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_vec) | set_vec;
  end

  // Fixed priority: the lowest eligible index is chosen.
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (pend[i] && elig[i]) begin
        pick_valid = 1'b1;
        pick_idx   = IW'(i);
      end
    end
  end

  always_comb begin
    pad = '0;
    pad[NVEC-1:0] = pend;
  end

  always_ff @(posedge clk) begin
    rd_data <= pad[rd_word*32 +: 32];
  end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_pkg::*;
#(
  parameter int NVEC     = 16,
  parameter int AW       = 10,
  parameter int TBL_BASE = 256,
  parameter int PBA_BASE = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NVEC-1:0] irq_req,
  input  logic            msi_active,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data
);
  localparam int          IW      = $clog2(NVEC);
  localparam int          NPBA    = (NVEC + 31) / 32;
  localparam int          PW      = (NPBA > 1) ? $clog2(NPBA) : 1;
  localparam logic [31:0] TBL_LO  = 32'(TBL_BASE);
  localparam logic [31:0] TBL_END = 32'(TBL_BASE + 4 * NVEC);
  localparam logic [31:0] PBA_LO  = 32'(PBA_BASE);
  localparam logic [31:0] PBA_END = 32'(PBA_BASE + NPBA);

  // Address decode.
  logic [31:0]   a32;
  logic          hit_ctrl, hit_toff, hit_poff, hit_tbl, hit_pba;
  logic [IW+1:0] toff;
  logic [IW-1:0] tbl_idx;
  fld_e          tbl_fld;
  logic [PW-1:0] pba_word;

  assign a32      = 32'(reg_addr);
  assign hit_ctrl = (a32 == 32'd0);
  assign hit_toff = (a32 == 32'd1);
  assign hit_poff = (a32 == 32'd2);
  assign hit_tbl  = (a32 >= TBL_LO) && (a32 < TBL_END);
  assign hit_pba  = (a32 >= PBA_LO) && (a32 < PBA_END);
  assign toff     = (IW+2)'(a32 - TBL_LO);
  assign tbl_idx  = toff[IW+1:2];
  assign tbl_fld  = fld_e'(toff[1:0]);
  assign pba_word = PW'(a32 - PBA_LO);

  // Control register.
  logic        ctrl_en, ctrl_fmask;
  logic [31:0] ctrl_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      ctrl_fmask <= 1'b0;
    end else if (reg_we && hit_ctrl) begin
      ctrl_en    <= reg_wdata[EN_BIT];
      ctrl_fmask <= reg_wdata[FMASK_BIT];
    end
  end

  assign ctrl_word = {ctrl_en, ctrl_fmask, 3'b000, 11'(NVEC - 1), 8'h00, CAP_ID};

  // Storage and pending array.
  logic [NVEC-1:0] vmask, elig, pend_vec;
  logic [31:0]     tbl_rdata, pba_rdata;
  logic            pick_valid, launch;
  logic [IW-1:0]   pick_idx;

  for (genvar g = 0; g < NVEC; g++) begin : g_elig
    assign elig[g] = ~vmask[g] & ~ctrl_fmask;
  end

  assign launch = pick_valid & ctrl_en & ~msi_active & ~msg_valid;

  msix_table #(.NVEC(NVEC), .IW(IW)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_we && hit_tbl),
    .wr_idx  (tbl_idx),
    .wr_fld  (tbl_fld),
    .wr_data (reg_wdata),
    .rd_idx  (tbl_idx),
    .rd_fld  (tbl_fld),
    .rd_data (tbl_rdata),
    .ld_en   (launch),
    .ld_idx  (pick_idx),
    .ld_addr (msg_addr),
    .ld_data (msg_data),
    .vmask   (vmask)
  );

  msix_pba #(.NVEC(NVEC), .IW(IW), .PW(PW)) u_pba (
    .clk        (clk),
    .rst        (rst),
    .set_vec    (irq_req),
    .clr_en     (launch),
    .clr_idx    (pick_idx),
    .elig       (elig),
    .rd_word    (pba_word),
    .rd_data    (pba_rdata),
    .pend       (pend_vec),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  // Message handshake: one message outstanding at a time.
  always_ff @(posedge clk) begin
    if (rst)            msg_valid <= 1'b0;
    else if (launch)    msg_valid <= 1'b1;
    else if (msg_ready) msg_valid <= 1'b0;
  end

  // Read return.
  rsrc_e       rsrc;
  logic [31:0] imm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsrc  <= SRC_NONE;
      imm_q <= '0;
    end else begin
      rsrc <= SRC_NONE;
      if (reg_re) begin
        if (hit_ctrl) begin
          rsrc  <= SRC_IMM;
          imm_q <= ctrl_word;
        end else if (hit_toff) begin
          rsrc  <= SRC_IMM;
          imm_q <= 32'(TBL_BASE * 4);
        end else if (hit_poff) begin
          rsrc  <= SRC_IMM;
          imm_q <= 32'(PBA_BASE * 4);
        end else if (hit_tbl) begin
          rsrc <= SRC_TBL;
        end else if (hit_pba) begin
          rsrc <= SRC_PBA;
        end
      end
    end
  end

  always_comb begin
    case (rsrc)
      SRC_IMM: reg_rdata = imm_q;
      SRC_TBL: reg_rdata = tbl_rdata;
      SRC_PBA: reg_rdata = pba_rdata;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk #(
  parameter int NVEC = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [63:0]     msg_addr,
  input logic [31:0]     msg_data,
  input logic            msi_active,
  input logic            ctrl_en,
  input logic            ctrl_fmask,
  input logic [NVEC-1:0] pend
);
  // R3
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!msg_valid && pend == '0));

  // R4
  from_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> ($past(pend) != '0));

  // R6 R9
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> ($past(ctrl_en) && !$past(ctrl_fmask)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R8
  coexist_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> !$past(msi_active));
endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NVEC(NVEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_addr   (msg_addr),
  .msg_data   (msg_data),
  .msi_active (msi_active),
  .ctrl_en    (ctrl_en),
  .ctrl_fmask (ctrl_fmask),
  .pend       (pend_vec)
);

// File: tb/test_msix_vec_ctrl.sv
`timescale 1ns/1ps
module test_msix_vec_ctrl;
  localparam int NVEC = 16;
  localparam int AW   = 10;
  localparam int TBL  = 256;
  localparam int PBA  = 128;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_we = 1'b0, reg_re = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NVEC-1:0] irq_req = '0;
  logic            msi_active = 1'b0;
  logic            msg_valid;
  logic            msg_ready = 1'b0;
  logic [63:0]     msg_addr;
  logic [31:0]     msg_data;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  msix_vec_ctrl #(.NVEC(NVEC), .AW(AW), .TBL_BASE(TBL), .PBA_BASE(PBA)) i_msix_vec_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .msi_active(msi_active), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NVEC-1:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    irq_req = '0;
  endtask

  function automatic logic [31:0] exp_lo(input int i);
    return 32'h1000_0000 | 32'(i << 4);
  endfunction
  function automatic logic [31:0] exp_dat(input int i);
    return 32'h0000_A000 + 32'(i);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] got [NVEC];
    int seen;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R3 R1 reset state and identification
    chk("R3 msg_valid after reset", 64'(msg_valid), 64'd0);
    reg_rd(0, d);   chk("R1 R3 control word", 64'(d), 64'h000F_0011);
    reg_rd(1, d);   chk("R1 table offset", 64'(d), 64'h400);
    reg_rd(2, d);   chk("R1 pending offset", 64'(d), 64'h200);
    reg_rd(PBA, d); chk("R3 pending empty", 64'(d), 64'd0);
    for (int i = 0; i < NVEC; i++) begin
      reg_rd(TBL + 4*i + 3, d); chk("R3 mask set at reset", 64'(d), 64'd1);
    end

    // R2 program and read back every entry
    for (int i = 0; i < NVEC; i++) begin
      reg_wr(TBL + 4*i + 0, exp_lo(i));
      reg_wr(TBL + 4*i + 1, 32'(i));
      reg_wr(TBL + 4*i + 2, exp_dat(i));
      reg_wr(TBL + 4*i + 3, 32'hFFFF_FFFE);
    end
    for (int i = 0; i < NVEC; i++) begin
      reg_rd(TBL + 4*i + 0, d); chk("R2 addr low", 64'(d), 64'(exp_lo(i)));
      reg_rd(TBL + 4*i + 1, d); chk("R2 addr high", 64'(d), 64'(i));
      reg_rd(TBL + 4*i + 2, d); chk("R2 data", 64'(d), 64'(exp_dat(i)));
      reg_rd(TBL + 4*i + 3, d); chk("R2 vctrl only bit 0", 64'(d), 64'd0);
    end

    // R1 enable; only bits 31:30 writable
    reg_wr(0, 32'h8000_FFFF);
    reg_rd(0, d); chk("R1 control after write", 64'(d), 64'h800F_0011);

    // R4 R7 R11 every vector alone
    for (int i = 0; i < NVEC; i++) begin
      pulse(NVEC'(1) << i);
      @(negedge clk);
      chk("R4 valid", 64'(msg_valid), 64'd1);
      chk("R4 addr", msg_addr, {32'(i), exp_lo(i)});
      chk("R4 data", 64'(msg_data), 64'(exp_dat(i)));
      repeat (2) @(negedge clk);
      chk("R7 held valid", 64'(msg_valid), 64'd1);
      chk("R7 held data", 64'(msg_data), 64'(exp_dat(i)));
      reg_rd(PBA, d); chk("R11 pending cleared", 64'(d), 64'd0);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
      chk("R7 consumed", 64'(msg_valid), 64'd0);
    end

    // R5 R10 all masked per entry
    for (int i = 0; i < NVEC; i++) reg_wr(TBL + 4*i + 3, 32'd1);
    pulse('1);
    repeat (4) @(negedge clk);
    chk("R5 no message when masked", 64'(msg_valid), 64'd0);
    reg_rd(PBA, d); chk("R5 pending all", 64'(d), 64'hFFFF);
    reg_wr(PBA, 32'd0);
    reg_rd(PBA, d); chk("R10 pending write ignored", 64'(d), 64'hFFFF);

    // R6 function mask over unmasked entries
    reg_wr(0, 32'hC000_0000);
    for (int i = 0; i < NVEC; i++) reg_wr(TBL + 4*i + 3, 32'd0);
    repeat (3) @(negedge clk);
    chk("R6 function mask blocks", 64'(msg_valid), 64'd0);
    reg_rd(PBA, d); chk("R6 pending kept", 64'(d), 64'hFFFF);
    msg_ready = 1'b1;
    reg_wr(0, 32'h8000_0000);
    seen = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (msg_valid) begin
        if (seen < NVEC) got[seen] = msg_data;
        seen++;
      end
    end
    msg_ready = 1'b0;
    chk("R6 all released", 64'(seen), 64'(NVEC));
    for (int i = 0; i < NVEC; i++) chk("R7 lowest first order", 64'(got[i]), 64'(exp_dat(i)));
    reg_rd(PBA, d); chk("R11 pending drained", 64'(d), 64'd0);

    // R8 other mechanism active
    msi_active = 1'b1;
    pulse(NVEC'(1) << 5);
    repeat (4) @(negedge clk);
    chk("R8 blocked", 64'(msg_valid), 64'd0);
    reg_rd(PBA, d); chk("R8 pending kept", 64'(d), 64'h20);
    msi_active = 1'b0;
    @(negedge clk);
    chk("R8 sent after release", 64'(msg_data), 64'(exp_dat(5)));
    chk("R8 valid after release", 64'(msg_valid), 64'd1);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;

    // R9 disabled
    reg_wr(0, 32'h0);
    pulse(NVEC'(1) << 9);
    repeat (4) @(negedge clk);
    chk("R9 blocked", 64'(msg_valid), 64'd0);
    reg_rd(PBA, d); chk("R9 pending recorded", 64'(d), 64'h200);
    reg_wr(0, 32'h8000_0000);
    @(negedge clk);
    chk("R9 valid after enable", 64'(msg_valid), 64'd1);
    chk("R9 data after enable", 64'(msg_data), 64'(exp_dat(9)));
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;

    // R5 per-entry unmask releases
    reg_wr(TBL + 4*2 + 3, 32'd1);
    pulse(NVEC'(1) << 2);
    repeat (3) @(negedge clk);
    chk("R5 single masked", 64'(msg_valid), 64'd0);
    reg_rd(PBA, d); chk("R5 single pending", 64'(d), 64'h4);
    reg_wr(TBL + 4*2 + 3, 32'd0);
    @(negedge clk);
    chk("R5 released valid", 64'(msg_valid), 64'd1);
    chk("R5 released addr", msg_addr, {32'd2, exp_lo(2)});
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule